// File: doc/BRIEF.md
# ADC Conversion Sequencer and Arbiter

This block decides which start-of-conversion slot owns a single successive-approximation converter that has only one sample-and-hold. Sixteen slots each carry a channel number, a trigger source number, a sample window length and an oversampling count. A pulse on the chosen trigger line marks a slot pending. The sequencer starts conversions strictly one after another. A low-index group of slots, whose size is set at run time, is served first. All other slots share the converter in round-robin order.

For each conversion the block raises a request toward the converter and holds the channel and window steady until a done pulse returns with a 12-bit sample. That sample goes into a result store indexed by slot, which the system reads through a synchronous read port. When a slot's last conversion finishes, any of four interrupt lines mapped to that slot fires. Each line acts either as a one-cycle pulse or as a sticky flag that software clears.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, conv_req, irq_out, ovf_flag and res_rd_data are all zero, and the rotation pointer is at slot 0.
- R2: Slot s becomes pending when trig_in bit cfg_trig_sel[4s+3:4s] is high at a clock edge. When the converter is idle, conv_req rises after the next edge, one cycle after the trigger was sampled.
- R3: A trigger for a slot that is already pending and not being granted in that cycle sets ovf_flag bit s and does not add a conversion. The flag stays set until ovf_clr bit s is high at an edge. A trigger in the cycle the slot is granted re-arms the slot without setting the flag.
- R4: Only one conversion runs at a time. conv_req stays high, with conv_chan and conv_win equal to the slot's cfg_chan and cfg_win fields, until conv_done is sampled. It is low in the following cycle.
- R5: Slots at or above the priority boundary are chosen round-robin. The pending slot found first when scanning upward (with wrap) from the pointer wins. After a round-robin grant the pointer moves to the granted slot plus one, modulo 16. High-priority grants leave the pointer where it is.
- R6: Slots with index below min(cfg_hp_cnt, 16) are high priority. The lowest-index pending one is served before any round-robin slot. A value of 16 or more makes every slot high priority.
- R7: A burst in progress is never interrupted. A slot that becomes pending during a burst, including a high-priority slot, is arbitrated only once that burst ends.
- R8: A slot whose cfg_osr field holds k runs k+1 conversions back to back from one trigger. Its result register ends with the last sample, and its completion is signalled once.
- R9: Each conversion writes its sample into the result entry of its slot. res_rd_data presents the entry at res_rd_addr one cycle later. The final sample is readable by the time the mapped interrupt rises.
- R10: Interrupt k responds only to completions of slot cfg_irq_slot[4k+3:4k]. In continuous mode (cfg_irq_oneshot bit k low) it is high for exactly one cycle, starting one edge after the final conv_done is sampled.
- R11: In one-shot mode interrupt k stays high after a completion until irq_clr bit k is high at an edge. A completion in the same cycle as the clear wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 16 | Trigger source pulses |
| cfg_trig_sel | input | 64 | Per-slot trigger source number, 4 bits per slot |
| cfg_chan | input | 64 | Per-slot channel number, 4 bits per slot |
| cfg_win | input | 96 | Per-slot sample window, 6 bits per slot |
| cfg_osr | input | 32 | Per-slot extra conversion count, 2 bits per slot |
| cfg_hp_cnt | input | 5 | Number of high-priority slots starting at slot 0 |
| cfg_irq_slot | input | 16 | Slot mapped to each interrupt, 4 bits per line |
| cfg_irq_oneshot | input | 4 | Per-line one-shot mode select |
| irq_clr | input | 4 | Per-line clear of a one-shot interrupt |
| ovf_clr | input | 16 | Per-slot clear of the overflow flag |
| conv_req | output | 1 | Conversion request to the converter |
| conv_chan | output | 4 | Channel of the requested conversion |
| conv_win | output | 6 | Sample window of the requested conversion |
| conv_done | input | 1 | One-cycle pulse marking a finished conversion |
| conv_data | input | 12 | Sample that comes with conv_done |
| res_rd_addr | input | 4 | Result read address (slot index) |
| res_rd_data | output | 12 | Result read data, one cycle after the address |
| ovf_flag | output | 16 | Per-slot trigger overflow flags |
| irq_out | output | 4 | End-of-conversion interrupt lines |

## Verification
A trigger driven at a falling edge is sampled at the next rising edge. The request must still be low at the following falling edge and high one cycle later, and the bench samples at exactly those two falling edges. A conversion result and its interrupt appear one edge after the rising edge that samples conv_done. A result read takes one more edge, so the bench sets the address at a falling edge and reads the data at the next falling edge. Conversion order is logged by a converter model at each request start and compared with an arithmetically computed order once the request line has gone low after the last expected start, which is when every burst has drained.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_NEXT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/adc_seq_trig.sv
// Per-slot pending latch and overflow flag.
module adc_seq_trig #(
  parameter int NUM_SLOTS = 16,
  parameter int NUM_TRIG  = 16,
  parameter int SLOT_W    = $clog2(NUM_SLOTS),
  parameter int TSEL_W    = $clog2(NUM_TRIG)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_TRIG-1:0]           trig_in,
  input  logic [NUM_SLOTS*TSEL_W-1:0]   cfg_trig_sel,
  input  logic                          grant_vld,
  input  logic [SLOT_W-1:0]             grant_slot,
  input  logic [NUM_SLOTS-1:0]          ovf_clr,
  output logic [NUM_SLOTS-1:0]          pend,
  output logic [NUM_SLOTS-1:0]          ovf_flag
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [TSEL_W-1:0] sel;
    logic              hit;
    logic              clr;
    logic              pend_q;
    logic              ovf_q;

    assign sel = cfg_trig_sel[s*TSEL_W +: TSEL_W];
    assign hit = trig_in[sel];
    assign clr = grant_vld && (grant_slot == SLOT_W'(s));

    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q <= 1'b0;
        ovf_q  <= 1'b0;
      end else begin
        pend_q <= hit | (pend_q & ~clr);
        if (hit && pend_q && !clr) begin
          ovf_q <= 1'b1;
        end else if (ovf_clr[s]) begin
          ovf_q <= 1'b0;
        end
      end
    end

    assign pend[s]     = pend_q;
    assign ovf_flag[s] = ovf_q;
  end
endmodule

// File: rtl/adc_seq_arb.sv
// Priority group first, then rotation over the remaining slots.
module adc_seq_arb #(
  parameter int NUM_SLOTS = 16,
  parameter int HP_W      = 5,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SLOTS-1:0] pend,
  input  logic [HP_W-1:0]      cfg_hp_cnt,
  input  logic                 take,
  output logic                 pick_vld,
  output logic [SLOT_W-1:0]    pick_slot
);
  logic [NUM_SLOTS-1:0] hp_mask;
  logic [NUM_SLOTS-1:0] hp_req;
  logic [NUM_SLOTS-1:0] rr_req;
  logic [SLOT_W-1:0]    rr_ptr;
  logic                 pick_hp;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_mask
    assign hp_mask[i] = (int'(cfg_hp_cnt) > i);
  end

  assign hp_req = pend & hp_mask;
  assign rr_req = pend & ~hp_mask;

  always_comb begin
    pick_vld  = 1'b0;
    pick_hp   = 1'b0;
    pick_slot = '0;
    // scan from the far end so the nearest pending slot is kept last
    for (int off = NUM_SLOTS - 1; off >= 0; off--) begin
      if (rr_req[(int'(rr_ptr) + off) % NUM_SLOTS]) begin
        pick_vld  = 1'b1;
        pick_slot = SLOT_W'((int'(rr_ptr) + off) % NUM_SLOTS);
      end
    end
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (hp_req[i]) begin
        pick_vld  = 1'b1;
        pick_hp   = 1'b1;
        pick_slot = SLOT_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_ptr <= '0;
    end else if (take && !pick_hp) begin
      if (pick_slot == SLOT_W'(NUM_SLOTS - 1)) begin
        rr_ptr <= '0;
      end else begin
        rr_ptr <= pick_slot + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
// Serialises conversions and runs oversampling bursts.
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int CH_W      = 4,
  parameter int WIN_W     = 6,
  parameter int OSR_W     = 2,
  parameter int RES_W     = 12,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         pick_vld,
  input  logic [SLOT_W-1:0]            pick_slot,
  input  logic [NUM_SLOTS*CH_W-1:0]    cfg_chan,
  input  logic [NUM_SLOTS*WIN_W-1:0]   cfg_win,
  input  logic [NUM_SLOTS*OSR_W-1:0]   cfg_osr,
  input  logic                         conv_done,
  input  logic [RES_W-1:0]             conv_data,
  output logic                         take,
  output logic                         conv_req,
  output logic [CH_W-1:0]              conv_chan,
  output logic [WIN_W-1:0]             conv_win,
  output logic                         wr_en,
  output logic [SLOT_W-1:0]            wr_addr,
  output logic [RES_W-1:0]             wr_data,
  output logic                         eoc_vld,
  output logic [SLOT_W-1:0]            eoc_slot
);
  seq_state_e        state;
  logic [SLOT_W-1:0] cur_slot;
  logic [OSR_W-1:0]  left;

  assign take = (state == ST_IDLE) && pick_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cur_slot  <= '0;
      left      <= '0;
      conv_req  <= 1'b0;
      conv_chan <= '0;
      conv_win  <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      eoc_vld   <= 1'b0;
      eoc_slot  <= '0;
    end else begin
      wr_en   <= 1'b0;
      eoc_vld <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (pick_vld) begin
            cur_slot  <= pick_slot;
            left      <= cfg_osr[pick_slot*OSR_W +: OSR_W];
            conv_chan <= cfg_chan[pick_slot*CH_W +: CH_W];
            conv_win  <= cfg_win[pick_slot*WIN_W +: WIN_W];
            conv_req  <= 1'b1;
            state     <= ST_CONV;
          end
        end
        ST_CONV: begin
          if (conv_done) begin
            conv_req <= 1'b0;
            wr_en    <= 1'b1;
            wr_addr  <= cur_slot;
            wr_data  <= conv_data;
            if (left == '0) begin
              eoc_vld  <= 1'b1;
              eoc_slot <= cur_slot;
              state    <= ST_IDLE;
            end else begin
              left  <= left - 1'b1;
              state <= ST_NEXT;
            end
          end
        end
        ST_NEXT: begin
          conv_req <= 1'b1;
          state    <= ST_CONV;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_resmem.sv
// Result store: synchronous write, registered synchronous read.
module adc_seq_resmem #(
  parameter int DEPTH  = 16,
  parameter int RES_W  = 12,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [RES_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [RES_W-1:0]  rd_data
);
  logic [RES_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= mem[rd_addr];
    end
  end
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int NUM_TRIG  = 16,
  parameter int CH_W      = 4,
  parameter int WIN_W     = 6,
  parameter int OSR_W     = 2,
  parameter int RES_W     = 12,
  parameter int NUM_IRQ   = 4,
  parameter int HP_W      = 5
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_TRIG-1:0]               trig_in,
  input  logic [NUM_SLOTS*$clog2(NUM_TRIG)-1:0] cfg_trig_sel,
  input  logic [NUM_SLOTS*CH_W-1:0]         cfg_chan,
  input  logic [NUM_SLOTS*WIN_W-1:0]        cfg_win,
  input  logic [NUM_SLOTS*OSR_W-1:0]        cfg_osr,
  input  logic [HP_W-1:0]                   cfg_hp_cnt,
  input  logic [NUM_IRQ*$clog2(NUM_SLOTS)-1:0] cfg_irq_slot,
  input  logic [NUM_IRQ-1:0]                cfg_irq_oneshot,
  input  logic [NUM_IRQ-1:0]                irq_clr,
  input  logic [NUM_SLOTS-1:0]              ovf_clr,
  output logic                              conv_req,
  output logic [CH_W-1:0]                   conv_chan,
  output logic [WIN_W-1:0]                  conv_win,
  input  logic                              conv_done,
  input  logic [RES_W-1:0]                  conv_data,
  input  logic [$clog2(NUM_SLOTS)-1:0]      res_rd_addr,
  output logic [RES_W-1:0]                  res_rd_data,
  output logic [NUM_SLOTS-1:0]              ovf_flag,
  output logic [NUM_IRQ-1:0]                irq_out
);
  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam int TSEL_W = $clog2(NUM_TRIG);

  logic [NUM_SLOTS-1:0] pend;
  logic                 take;
  logic                 pick_vld;
  logic [SLOT_W-1:0]    pick_slot;
  logic                 wr_en;
  logic [SLOT_W-1:0]    wr_addr;
  logic [RES_W-1:0]     wr_data;
  logic                 eoc_vld;
  logic [SLOT_W-1:0]    eoc_slot;

  adc_seq_trig #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_TRIG(NUM_TRIG), .SLOT_W(SLOT_W), .TSEL_W(TSEL_W)
  ) u_trig (
    .clk(clk), .rst(rst), .trig_in(trig_in), .cfg_trig_sel(cfg_trig_sel),
    .grant_vld(take), .grant_slot(pick_slot), .ovf_clr(ovf_clr),
    .pend(pend), .ovf_flag(ovf_flag)
  );

  adc_seq_arb #(
    .NUM_SLOTS(NUM_SLOTS), .HP_W(HP_W), .SLOT_W(SLOT_W)
  ) u_arb (
    .clk(clk), .rst(rst), .pend(pend), .cfg_hp_cnt(cfg_hp_cnt), .take(take),
    .pick_vld(pick_vld), .pick_slot(pick_slot)
  );

  adc_seq_ctrl #(
    .NUM_SLOTS(NUM_SLOTS), .CH_W(CH_W), .WIN_W(WIN_W), .OSR_W(OSR_W),
    .RES_W(RES_W), .SLOT_W(SLOT_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .pick_vld(pick_vld), .pick_slot(pick_slot),
    .cfg_chan(cfg_chan), .cfg_win(cfg_win), .cfg_osr(cfg_osr),
    .conv_done(conv_done), .conv_data(conv_data), .take(take),
    .conv_req(conv_req), .conv_chan(conv_chan), .conv_win(conv_win),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .eoc_vld(eoc_vld), .eoc_slot(eoc_slot)
  );

  adc_seq_resmem #(
    .DEPTH(NUM_SLOTS), .RES_W(RES_W), .ADDR_W(SLOT_W)
  ) u_mem (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(res_rd_addr), .rd_data(res_rd_data)
  );

  // End-of-conversion interrupt lines
  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
    logic hit;
    logic irq_q;

    assign hit = eoc_vld && (eoc_slot == cfg_irq_slot[k*SLOT_W +: SLOT_W]);

    always_ff @(posedge clk) begin
      if (rst) begin
        irq_q <= 1'b0;
      end else if (cfg_irq_oneshot[k]) begin
        if (hit) begin
          irq_q <= 1'b1;
        end else if (irq_clr[k]) begin
          irq_q <= 1'b0;
        end
      end else begin
        irq_q <= hit;
      end
    end

    assign irq_out[k] = irq_q;
  end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int NUM_SLOTS = 16,
  parameter int NUM_IRQ   = 4,
  parameter int CH_W      = 4,
  parameter int WIN_W     = 6
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 conv_req,
  input logic                 conv_done,
  input logic [CH_W-1:0]      conv_chan,
  input logic [WIN_W-1:0]     conv_win,
  input logic [NUM_SLOTS-1:0] ovf_flag,
  input logic [NUM_SLOTS-1:0] ovf_clr,
  input logic [NUM_IRQ-1:0]   irq_out,
  input logic [NUM_IRQ-1:0]   irq_clr,
  input logic [NUM_IRQ-1:0]   cfg_irq_oneshot
);
  // R4: a request is held until the converter answers
  p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
    conv_req && !conv_done |=> conv_req);

  // R4: channel and window do not move while a request is open
  p_req_stable_r4: assert property (@(posedge clk) disable iff (rst)
    conv_req && !conv_done |=> $stable(conv_chan) && $stable(conv_win));

  // R4: the request drops right after its done pulse
  p_req_drop_r4: assert property (@(posedge clk) disable iff (rst)
    conv_req && conv_done |=> !conv_req);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_ovf
    // R3: an overflow flag only falls through its clear
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
      ovf_flag[s] && !ovf_clr[s] |=> ovf_flag[s]);
  end

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
    // R11: a one-shot line holds until cleared
    p_oneshot_hold_r11: assert property (@(posedge clk) disable iff (rst)
      cfg_irq_oneshot[k] && irq_out[k] && !irq_clr[k] |=> irq_out[k]);

    // R10: a continuous line is a single-cycle pulse
    p_pulse_width_r10: assert property (@(posedge clk) disable iff (rst)
      !cfg_irq_oneshot[k] && irq_out[k] |=> !irq_out[k]);
  end
endmodule

bind adc_seq_top adc_seq_chk #(
  .NUM_SLOTS(NUM_SLOTS), .NUM_IRQ(NUM_IRQ), .CH_W(CH_W), .WIN_W(WIN_W)
) u_chk (
  .clk(clk), .rst(rst), .conv_req(conv_req), .conv_done(conv_done),
  .conv_chan(conv_chan), .conv_win(conv_win), .ovf_flag(ovf_flag),
  .ovf_clr(ovf_clr), .irq_out(irq_out), .irq_clr(irq_clr),
  .cfg_irq_oneshot(cfg_irq_oneshot)
);

// File: tb/tb_adc_seq_top.sv
module tb_adc_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;

  logic          clk;
  logic          rst;
  logic [15:0]   trig_in;
  logic [63:0]   cfg_trig_sel;
  logic [63:0]   cfg_chan;
  logic [95:0]   cfg_win;
  logic [31:0]   cfg_osr;
  logic [4:0]    cfg_hp_cnt;
  logic [15:0]   cfg_irq_slot;
  logic [3:0]    cfg_irq_oneshot;
  logic [3:0]    irq_clr;
  logic [15:0]   ovf_clr;
  logic          conv_req;
  logic [3:0]    conv_chan;
  logic [5:0]    conv_win;
  logic          conv_done;
  logic [11:0]   conv_data;
  logic [3:0]    res_rd_addr;
  logic [11:0]   res_rd_data;
  logic [15:0]   ovf_flag;
  logic [3:0]    irq_out;

  adc_seq_top dut (
    .clk(clk), .rst(rst), .trig_in(trig_in), .cfg_trig_sel(cfg_trig_sel),
    .cfg_chan(cfg_chan), .cfg_win(cfg_win), .cfg_osr(cfg_osr),
    .cfg_hp_cnt(cfg_hp_cnt), .cfg_irq_slot(cfg_irq_slot),
    .cfg_irq_oneshot(cfg_irq_oneshot), .irq_clr(irq_clr), .ovf_clr(ovf_clr),
    .conv_req(conv_req), .conv_chan(conv_chan), .conv_win(conv_win),
    .conv_done(conv_done), .conv_data(conv_data), .res_rd_addr(res_rd_addr),
    .res_rd_data(res_rd_data), .ovf_flag(ovf_flag), .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int log_chan [0:511];
  int log_win  [0:511];
  int log_data [0:511];
  int log_n;
  int irq_hi [0:3];
  int exp_q [0:63];
  int exp_n;
  int tb_ptr;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // behavioural converter: logs each request start, answers after the window
  initial begin : conv_model
    bit active;
    int wait_cnt;
    int seq;
    active = 0; wait_cnt = 0; seq = 0;
    log_n = 0;
    conv_done = 1'b0;
    conv_data = '0;
    forever begin
      @(negedge clk);
      if (conv_done) begin
        conv_done = 1'b0;
      end else if (!active && conv_req) begin
        active = 1;
        wait_cnt = int'(conv_win);
        log_chan[log_n] = int'(conv_chan);
        log_win[log_n]  = int'(conv_win);
        log_n++;
      end else if (active) begin
        if (wait_cnt == 0) begin
          conv_data = {conv_chan, 8'(seq)};
          log_data[log_n-1] = int'({conv_chan, 8'(seq)});
          conv_done = 1'b1;
          seq++;
          active = 0;
        end else begin
          wait_cnt--;
        end
      end
    end
  end

  initial begin : irq_mon
    irq_hi[0] = 0; irq_hi[1] = 0; irq_hi[2] = 0; irq_hi[3] = 0;
    forever begin
      @(negedge clk);
      for (int k = 0; k < 4; k++) if (irq_out[k]) irq_hi[k]++;
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD*150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    trig_in = '0;
    irq_clr = '0;
    ovf_clr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tb_ptr = 0;
  endtask

  task automatic fire(input logic [15:0] m);
    @(negedge clk);
    trig_in = m;
    @(negedge clk);
    trig_in = '0;
  endtask

  task automatic wait_done(input int target);
    while (log_n < target) @(negedge clk);
    while (conv_req) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic read_res(input int s, output int v);
    @(negedge clk);
    res_rd_addr = 4'(s);
    @(negedge clk);
    v = int'(res_rd_data);
  endtask

  // expected order when all slots of m are pending at once
  task automatic build_exp(input logic [15:0] m, input int hp);
    int hpl;
    int pick;
    hpl = (hp > NS) ? NS : hp;
    exp_n = 0;
    while (m != 0) begin
      pick = -1;
      for (int i = 0; i < NS; i++)
        if (pick < 0 && i < hpl && m[i]) pick = i;
      if (pick < 0) begin
        for (int off = 0; off < NS; off++)
          if (pick < 0 && m[(tb_ptr + off) % NS] && ((tb_ptr + off) % NS) >= hpl)
            pick = (tb_ptr + off) % NS;
        tb_ptr = (pick + 1) % NS;
      end
      m[pick] = 1'b0;
      exp_q[exp_n] = pick;
      exp_n++;
    end
  endtask

  task automatic cmp_order(input int base, input string rq);
    chk(log_n - base == exp_n, rq, log_n - base, exp_n);
    for (int i = 0; i < exp_n; i++)
      chk(log_chan[base+i] == exp_q[i], rq, log_chan[base+i], exp_q[i]);
  endtask

  initial begin : main
    int base;
    int v;
    int h0;
    int h1;
    int h2;
    rst = 1'b1;
    trig_in = '0; irq_clr = '0; ovf_clr = '0; res_rd_addr = '0;
    cfg_hp_cnt = '0; cfg_irq_oneshot = '0; cfg_irq_slot = '0; cfg_osr = '0;
    for (int s = 0; s < NS; s++) begin
      cfg_trig_sel[s*4 +: 4] = 4'(s);
      cfg_chan[s*4 +: 4]     = 4'(s);
      cfg_win[s*6 +: 6]      = 6'((s*5) % 13);
    end
    do_reset();

    // R1: reset state
    @(negedge clk);
    chk(conv_req == 1'b0, "R1 conv_req", int'(conv_req), 0);
    chk(irq_out == '0, "R1 irq_out", int'(irq_out), 0);
    chk(ovf_flag == '0, "R1 ovf_flag", int'(ovf_flag), 0);
    chk(res_rd_data == '0, "R1 res_rd_data", int'(res_rd_data), 0);

    // R2 R4 R9 R10: one slot at a time over every slot
    for (int s = 0; s < NS; s++) begin
      cfg_irq_slot[3:0] = 4'(s);
      base = log_n;
      h0 = irq_hi[0];
      @(negedge clk);
      trig_in = 16'(1 << s);
      @(negedge clk);
      trig_in = '0;
      chk(conv_req == 1'b0, "R2 req not yet", int'(conv_req), 0);
      @(negedge clk);
      chk(conv_req == 1'b1, "R2 req raised", int'(conv_req), 1);
      wait_done(base + 1);
      chk(log_n - base == 1, "R4 one conversion", log_n - base, 1);
      chk(log_chan[base] == s, "R4 channel", log_chan[base], s);
      chk(log_win[base] == (s*5) % 13, "R4 window", log_win[base], (s*5) % 13);
      chk(irq_hi[0] - h0 == 1, "R10 pulse", irq_hi[0] - h0, 1);
      read_res(s, v);
      chk(v == log_data[base], "R9 result", v, log_data[base]);
    end

    // R2: trigger routing through a non-identity select
    do_reset();
    cfg_trig_sel[3*4 +: 4] = 4'd7;
    base = log_n;
    fire(16'h0080);
    wait_done(base + 2);
    build_exp(16'h0088, 0);
    cmp_order(base, "R2 routing");
    cfg_trig_sel[3*4 +: 4] = 4'd3;

    // R5: rotation with pointer moved by a prior grant
    do_reset();
    base = log_n;
    fire(16'h0200);
    wait_done(base + 1);
    build_exp(16'h0200, 0);
    base = log_n;
    fire(16'hFFFF);
    wait_done(base + 16);
    build_exp(16'hFFFF, 0);
    cmp_order(base, "R5 rotation");

    // R6: priority group served first
    do_reset();
    cfg_hp_cnt = 5'd4;
    base = log_n;
    fire(16'h0200);
    wait_done(base + 1);
    build_exp(16'h0200, 4);
    base = log_n;
    fire(16'hFFFF);
    wait_done(base + 16);
    build_exp(16'hFFFF, 4);
    cmp_order(base, "R6 priority");

    // R6 R5: boundary above slot count, then pointer untouched
    do_reset();
    cfg_hp_cnt = 5'd31;
    base = log_n;
    fire(16'hFFFF);
    wait_done(base + 16);
    build_exp(16'hFFFF, 31);
    cmp_order(base, "R6 all priority");
    cfg_hp_cnt = 5'd0;
    base = log_n;
    fire(16'h8001);
    wait_done(base + 2);
    build_exp(16'h8001, 0);
    cmp_order(base, "R5 pointer kept");

    // R7 R8: burst not preempted by a priority slot
    do_reset();
    cfg_hp_cnt = 5'd4;
    cfg_osr[8*2 +: 2] = 2'd2;
    base = log_n;
    fire(16'h0100);
    while (log_n == base) @(negedge clk);
    fire(16'h0204);
    wait_done(base + 5);
    exp_q[0] = 8; exp_q[1] = 8; exp_q[2] = 8; exp_q[3] = 2; exp_q[4] = 9;
    exp_n = 5;
    cmp_order(base, "R7 no preempt");
    cfg_osr[8*2 +: 2] = 2'd0;
    cfg_hp_cnt = 5'd0;

    // R8: oversampling burst with a single completion
    do_reset();
    cfg_osr[4*2 +: 2] = 2'd3;
    cfg_irq_slot[3:0] = 4'd4;
    cfg_irq_oneshot = '0;
    h0 = irq_hi[0];
    base = log_n;
    fire(16'h0010);
    wait_done(base + 4);
    chk(log_n - base == 4, "R8 burst length", log_n - base, 4);
    for (int i = 0; i < 4; i++)
      chk(log_chan[base+i] == 4, "R8 burst channel", log_chan[base+i], 4);
    chk(irq_hi[0] - h0 == 1, "R8 single completion", irq_hi[0] - h0, 1);
    read_res(4, v);
    chk(v == log_data[base+3], "R8 last sample kept", v, log_data[base+3]);
    cfg_osr[4*2 +: 2] = 2'd0;

    // R3: re-trigger while pending, re-arm during grant
    do_reset();
    base = log_n;
    fire(16'hFFFF);
    fire(16'h0021);
    wait_done(base + 17);
    exp_n = 17;
    for (int i = 0; i < 16; i++) exp_q[i] = i;
    exp_q[16] = 0;
    cmp_order(base, "R3 ignored trigger");
    chk(ovf_flag == 16'h0020, "R3 overflow flag", int'(ovf_flag), 32);
    @(negedge clk);
    ovf_clr = 16'h0020;
    @(negedge clk);
    ovf_clr = '0;
    chk(ovf_flag == '0, "R3 overflow cleared", int'(ovf_flag), 0);

    // R10 R11: mapping, one-shot hold, clear, set over clear
    do_reset();
    cfg_irq_slot = {4'd0, 4'd7, 4'd6, 4'd6};
    cfg_irq_oneshot = 4'b0010;
    h0 = irq_hi[0]; h2 = irq_hi[2];
    base = log_n;
    fire(16'h0040);
    wait_done(base + 1);
    repeat (10) @(negedge clk);
    chk(irq_out[1] == 1'b1, "R11 one-shot held", int'(irq_out[1]), 1);
    chk(irq_out[0] == 1'b0, "R10 continuous low after pulse", int'(irq_out[0]), 0);
    chk(irq_hi[0] - h0 == 1, "R10 continuous pulse", irq_hi[0] - h0, 1);
    chk(irq_hi[2] - h2 == 0, "R10 unmapped line quiet", irq_hi[2] - h2, 0);
    @(negedge clk);
    irq_clr = 4'b0010;
    @(negedge clk);
    irq_clr = '0;
    chk(irq_out[1] == 1'b0, "R11 cleared", int'(irq_out[1]), 0);
    irq_clr = 4'b0010;
    h1 = irq_hi[1];
    base = log_n;
    fire(16'h0040);
    wait_done(base + 1);
    chk(irq_hi[1] - h1 == 1, "R11 set wins over clear", irq_hi[1] - h1, 1);
    chk(irq_out[1] == 1'b0, "R11 clear after set", int'(irq_out[1]), 0);
    irq_clr = '0;

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule